// File: doc/BRIEF.md
# Accelerator Instruction Dispatch Arbiter

This block sits between a host processor's fetched instruction stream and a bank of custom accelerator units. Each presented instruction is partly decoded. A standard instruction is handed straight to the host. An extended instruction that requests an accelerator run carries a small table index. That index reads a programmable lookup table, and the entry it finds names the accelerator that receives a one-cycle start pulse.

While the launched unit works, the host is stalled, and a new instruction is neither passed on nor accepted. When the launched unit raises its completion signal, the stall drops on the next cycle. A table entry that is not valid, or that names a unit outside the bank, launches nothing. It raises a one-cycle error flag instead, and the host is never stalled. The table is loaded through a simple write port before the run commands are issued.

Top module: `accel_dispatch`

## Requirements
- R1: An instruction whose opcode field `instr_word[31:26]` differs from 6'h2F is standard. When `instr_valid` is high and `stall` is low, `host_valid` is high in that same cycle and `host_word` equals `instr_word`.
- R2: An extended instruction (opcode 6'h2F) with bit 25 low is a non-run command. It gives no `host_valid`, no start pulse and no error.
- R3: An extended instruction with bit 25 high is a run command. Its index `instr_word[5:0]` selects the table entry. A write with `cfg_we` high stores {`cfg_valid`, `cfg_unit`} at `cfg_addr` on the rising clock edge.
- R4: Take a run command accepted at a clock edge whose entry is valid. In the cycle after that edge, `acc_start` is one-hot on the entry's unit number (bit n for unit n) for exactly one cycle.
- R5: `stall` rises in the same cycle as the start pulse. It stays high until the launched unit's `acc_done` bit is sampled high, and it is low in the following cycle. Done bits from other units have no effect on it.
- R6: While `stall` is high, a presented instruction is not accepted. It gives no `host_valid` and no further start pulse.
- R7: A run command whose entry is marked invalid gives `map_error` high for one cycle in the cycle after acceptance. It gives no start pulse and no stall.
- R8: After reset, `stall`, `acc_start` and `map_error` are low, and every table entry is invalid.
- R9: An entry whose unit number is equal to or greater than the unit count is handled as invalid, as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Fetched instruction present |
| instr_word | input | IW | Fetched instruction |
| host_valid | output | 1 | Standard instruction handed to host |
| host_word | output | IW | Instruction handed to host |
| stall | output | 1 | Host held while an accelerator runs |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | ADDR_W | Table write index |
| cfg_valid | input | 1 | Valid mark of written entry |
| cfg_unit | input | UNIT_W | Unit number of written entry |
| acc_start | output | N_UNITS | One-hot start pulses |
| acc_done | input | N_UNITS | Completion flags from units |
| map_error | output | 1 | Run command hit an unusable entry |

## Verification
The hardest situation to reach from the ports is traffic that arrives while the host is stalled. This covers a second run command, a standard instruction, and a completion flag from a unit other than the one launched, all landing inside the busy window. The bench programs every table index with a computed pattern that mixes valid entries, entries marked invalid and unit numbers beyond the six-unit bank. It then issues a run command for every index. For every launch it picks a random unit latency, and in the first busy cycle it injects a rejected instruction and a stray completion from another unit. The stall must ignore both and end exactly one cycle after the real completion.

// File: rtl/accel_dispatch_pkg.sv
package accel_dispatch_pkg;

  typedef enum logic [1:0] {
    CLS_STD   = 2'd0,
    CLS_RUN   = 2'd1,
    CLS_OTHER = 2'd2
  } instr_cls_e;

  localparam logic [5:0] EXT_OPCODE = 6'h2F;

  function automatic instr_cls_e classify(input logic [5:0] opc, input logic run_bit);
    if (opc != EXT_OPCODE) return CLS_STD;
    if (run_bit)           return CLS_RUN;
    return CLS_OTHER;
  endfunction

  function automatic int unsigned onehot_of(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/instr_classifier.sv
module instr_classifier
  import accel_dispatch_pkg::*;
#(
  parameter int IW     = 32,
  parameter int ADDR_W = 6
) (
  input  logic [IW-1:0]     word,
  output instr_cls_e        cls,
  output logic [ADDR_W-1:0] index
);
  always_comb begin
    cls   = classify(word[IW-1 -: 6], word[IW-7]);
    index = word[ADDR_W-1:0];
  end
endmodule

// File: rtl/map_table.sv
module map_table #(
  parameter int ADDR_W = 6,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wvalid,
  input  logic [UNIT_W-1:0] wunit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rvalid,
  output logic [UNIT_W-1:0] runit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  valid_q;
  logic [UNIT_W-1:0] unit_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[waddr] <= wvalid;
    end
  end

  always_ff @(posedge clk) begin
    if (we) unit_q[waddr] <= wunit;
  end

  assign rvalid = valid_q[raddr];
  assign runit  = unit_q[raddr];
endmodule

// File: rtl/start_demux.sv
module start_demux #(
  parameter int N_UNITS = 8,
  parameter int UNIT_W  = 3
) (
  input  logic              fire,
  input  logic [UNIT_W-1:0] unit,
  output logic [N_UNITS-1:0] start
);
  for (genvar i = 0; i < N_UNITS; i++) begin : g_lane
    assign start[i] = fire && (unit == UNIT_W'(i));
  end
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl #(
  parameter int N_UNITS = 8,
  parameter int UNIT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               reject,
  input  logic [UNIT_W-1:0]  unit_in,
  input  logic [N_UNITS-1:0] done,
  output logic               busy,
  output logic               fire,
  output logic               err,
  output logic [UNIT_W-1:0]  sel,
  output logic               done_hit
);
  always_comb begin
    done_hit = 1'b0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (busy && sel == UNIT_W'(i) && done[i]) done_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fire <= 1'b0;
      err  <= 1'b0;
      sel  <= '0;
    end else begin
      fire <= launch;
      err  <= reject;
      if (launch) begin
        busy <= 1'b1;
        sel  <= unit_in;
      end else if (done_hit) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/accel_dispatch.sv
module accel_dispatch
  import accel_dispatch_pkg::*;
#(
  parameter int IW      = 32,
  parameter int ADDR_W  = 6,
  parameter int N_UNITS = 8,
  parameter int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [IW-1:0]      instr_word,
  output logic               host_valid,
  output logic [IW-1:0]      host_word,
  output logic               stall,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic               cfg_valid,
  input  logic [UNIT_W-1:0]  cfg_unit,
  output logic [N_UNITS-1:0] acc_start,
  input  logic [N_UNITS-1:0] acc_done,
  output logic               map_error
);
  localparam logic [UNIT_W:0] UNIT_LIMIT = (UNIT_W+1)'(N_UNITS);

  instr_cls_e        cls;
  logic [ADDR_W-1:0] tbl_index;
  logic              tbl_valid;
  logic [UNIT_W-1:0] tbl_unit;
  logic              busy, fire, err;
  logic [UNIT_W-1:0] sel_unit;
  logic              unit_done_hit;
  logic              run_accept, entry_usable, launch, reject;

  instr_classifier #(.IW(IW), .ADDR_W(ADDR_W)) u_dec (
    .word(instr_word), .cls(cls), .index(tbl_index)
  );

  map_table #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .waddr(cfg_addr), .wvalid(cfg_valid), .wunit(cfg_unit),
    .raddr(tbl_index), .rvalid(tbl_valid), .runit(tbl_unit)
  );

  assign run_accept   = instr_valid && !busy && (cls == CLS_RUN);
  assign entry_usable = tbl_valid && ({1'b0, tbl_unit} < UNIT_LIMIT);
  assign launch       = run_accept && entry_usable;
  assign reject       = run_accept && !entry_usable;

  dispatch_ctrl #(.N_UNITS(N_UNITS), .UNIT_W(UNIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .reject(reject), .unit_in(tbl_unit), .done(acc_done),
    .busy(busy), .fire(fire), .err(err), .sel(sel_unit), .done_hit(unit_done_hit)
  );

  start_demux #(.N_UNITS(N_UNITS), .UNIT_W(UNIT_W)) u_demux (
    .fire(fire), .unit(sel_unit), .start(acc_start)
  );

  assign host_valid = instr_valid && !busy && (cls == CLS_STD);
  assign host_word  = instr_word;
  assign stall      = busy;
  assign map_error  = err;
endmodule

// File: rtl/accel_dispatch_chk.sv
module accel_dispatch_chk #(
  parameter int N_UNITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               stall,
  input logic [N_UNITS-1:0] acc_start,
  input logic               map_error,
  input logic               unit_done_hit
);
  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_start));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start != '0) |=> (acc_start == '0));

  assert_stall_with_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start != '0) |-> stall);

  assert_stall_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> (acc_start != '0));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done_hit |=> !stall);

  assert_no_host_in_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !host_valid);

  assert_error_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    map_error |-> (acc_start == '0 && !stall));
endmodule

bind accel_dispatch accel_dispatch_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .stall(stall),
  .acc_start(acc_start), .map_error(map_error), .unit_done_hit(unit_done_hit)
);

// File: tb/accel_dispatch_tb.sv
`timescale 1ns/1ps
module accel_dispatch_tb;
  localparam int IW = 32;
  localparam int AW = 6;
  localparam int NU = 6;
  localparam int UW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_valid;
  logic [IW-1:0] instr_word;
  logic          host_valid;
  logic [IW-1:0] host_word;
  logic          stall;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic          cfg_valid;
  logic [UW-1:0] cfg_unit;
  logic [NU-1:0] acc_start;
  logic [NU-1:0] acc_done;
  logic          map_error;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  accel_dispatch #(.IW(IW), .ADDR_W(AW), .N_UNITS(NU)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .host_valid(host_valid), .host_word(host_word), .stall(stall),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .cfg_unit(cfg_unit),
    .acc_start(acc_start), .acc_done(acc_done), .map_error(map_error)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk_run(input int idx);
    return {6'h2F, 1'b1, 19'd0, 6'(idx)};
  endfunction

  function automatic int pat_unit(input int a);
    return (a * 3) % 8;
  endfunction

  function automatic bit pat_valid(input int a);
    return (a % 5) != 0;
  endfunction

  task automatic run_one(input int a);
    int u;
    int lat;
    bit usable;
    u = pat_unit(a);
    usable = pat_valid(a) && (u < NU);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = mk_run(a);
    #1 chk(host_valid == 1'b0, "R3 run command not sent to host", host_valid, 0);
    @(negedge clk);
    instr_valid = 1'b0;
    if (!usable) begin
      if (u >= NU) chk(map_error == 1'b1, "R9 out-of-bank unit error", map_error, 1);
      else         chk(map_error == 1'b1, "R7 invalid entry error", map_error, 1);
      chk(acc_start == '0, "R7 no start on error", acc_start, 0);
      chk(stall == 1'b0, "R7 no stall on error", stall, 0);
      @(negedge clk);
      chk(map_error == 1'b0, "R7 error lasts one cycle", map_error, 0);
    end else begin
      chk(acc_start == NU'(1 << u), "R4 one-hot start", acc_start, 1 << u);
      chk(stall == 1'b1, "R5 stall with start", stall, 1);
      chk(map_error == 1'b0, "R4 no error on launch", map_error, 0);
      lat = $urandom_range(1, 5);
      for (int k = 0; k < lat; k++) begin
        if (k == 0) begin
          instr_valid = 1'b1;
          instr_word  = (a % 2 == 1) ? 32'h0400_0000 + 32'(a) : mk_run(a);
          acc_done    = NU'(1 << ((u + 1) % NU));
          #1 chk(host_valid == 1'b0, "R6 no host during stall", host_valid, 0);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        acc_done    = '0;
        chk(acc_start == '0, "R6 no start while busy", acc_start, 0);
        chk(stall == 1'b1, "R5 stall held until done", stall, 1);
      end
      acc_done = NU'(1 << u);
      @(negedge clk);
      acc_done = '0;
      chk(stall == 1'b0, "R5 stall drops after done", stall, 0);
      chk(acc_start == '0, "R6 rejected command not relaunched", acc_start, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_valid = 1'b0; cfg_unit = '0; acc_done = '0;
    repeat (3) @(negedge clk);
    chk(stall == 1'b0, "R8 reset stall", stall, 0);
    chk(acc_start == '0, "R8 reset start", acc_start, 0);
    chk(map_error == 1'b0, "R8 reset error", map_error, 0);
    rst_n = 1'b1;

    // R8: unprogrammed entries are invalid
    @(negedge clk);
    instr_valid = 1'b1; instr_word = mk_run(7);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(map_error == 1'b1, "R8 entries invalid after reset", map_error, 1);
    chk(acc_start == '0, "R8 no start after reset", acc_start, 0);

    // R1 / R2: sweep every opcode
    for (int op = 0; op < 64; op++) begin
      for (int rb = 0; rb < 2; rb++) begin
        if (op == 6'h2F && rb == 1) continue;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {6'(op), 1'(rb), 25'h0A5A5A5 ^ 25'(op * 977)};
        #1;
        if (op != 6'h2F) begin
          chk(host_valid == 1'b1, "R1 standard passes to host", host_valid, 1);
          chk(host_word == instr_word, "R1 host word", host_word, instr_word);
        end else begin
          chk(host_valid == 1'b0, "R2 non-run command not sent to host", host_valid, 0);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        chk(acc_start == '0 && map_error == 1'b0, "R2 no start or error", {acc_start, map_error}, 0);
      end
    end

    // R3: program the table
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 6'(a); cfg_valid = pat_valid(a); cfg_unit = 3'(pat_unit(a));
    end
    @(negedge clk);
    cfg_we = 1'b0;

    for (int a = 0; a < 64; a++) run_one(a);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule